// File: doc/BRIEF.md
# Set/Clear Peripheral Clock Gate Controller

This block holds the on/off state of up to 64 peripheral clocks, grouped into banks of 32, and drives one enable line per clock towards the clock-gate cells. Software never rewrites a whole enable word. Each bank has a set port and a clear port. Writing a 1 to a bit of the set port turns that one clock on. Writing a 1 to a bit of the clear port turns it off. Zero bits leave their clocks alone, so two drivers can manage different clocks without a lock.

Each bank also offers two readbacks. The request word shows what software last asked for. The status word shows what the gated domain actually runs. The status word, and the enable outputs with it, trail the request by a programmable number of cycles (STATUS_DELAY, default 2). This models the synchroniser in the gated domain. Driver code writes a request, then polls status until the bit it wrote reads back the value it asked for.

The bus port is a single-cycle strobe with write flag, byte address and 32-bit data. Accesses are word-aligned. Read data is registered and appears in the cycle after the read strobe.

Top module: `ckg_ctrl`

## Requirements
- R1: While rst is high, and in the first cycle after it is released, every request bit and every status bit equals the RESET_EN mask (default: only clock 2 on, value 64'h4), and gate_en equals that mask.
- R2: A write to a bank's set port (bank 0 at 0x24, bank 1 at 0x34) sets each request bit whose data bit is 1 and leaves every other request bit unchanged, including bits already set.
- R3: A write to a bank's clear port (bank 0 at 0x28, bank 1 at 0x38) clears each request bit whose data bit is 1 and leaves every other request bit unchanged.
- R4: Clock N belongs to bank 1 when N > 31 and otherwise to bank 0. It uses bit N mod 32 of that bank's ports, and its enable is gate_en[N].
- R5: A read of a bank's request word (bank 0 at 0x2C, bank 1 at 0x3C) returns the request including every write accepted in an earlier cycle.
- R6: The status word (bank 0 at 0x30, bank 1 at 0x40) and gate_en follow the request with a delay of exactly STATUS_DELAY cycles. A write at clock edge E changes gate_en after edge E+STATUS_DELAY. A status read strobed at edge E+STATUS_DELAY+1 is the first read to return the new value.
- R7: Reads of the set and clear ports return 0. Writes to the request and status addresses change nothing.
- R8: bus_rdata is updated at the edge that samples a read strobe and holds at all other edges. Addresses outside 0x24..0x43 read as 0 and ignore writes. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| gate_en | output | NUM_BANKS*32 | Per-clock gate enable (actual state) |

## Verification
A write at edge E changes the request word at that same edge, so a read strobed at E+1 already returns the new request. With the default delay, gate_en changes after edge E+2. The status word first shows the new value for a read strobed at E+3. The bench issues back-to-back reads right after a write and expects the old status at E+1 and E+2 and the new one at E+3. It also samples gate_en on the falling edges after E, E+1 and E+2. Every read pushes its expected word into a queue, and a monitor pops and compares that word on the falling edge after the sampling edge.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    localparam int DATA_W      = 32;
    localparam int BANK_STRIDE = 16;

    typedef enum logic [1:0] {
        KIND_SET  = 2'd0,
        KIND_CLR  = 2'd1,
        KIND_REQ  = 2'd2,
        KIND_STAT = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic [3:0] bank;
        reg_kind_e kind;
    } access_t;

    // Map a byte address onto bank index and register kind.
    function automatic access_t map_addr(input logic [15:0] addr,
                                         input logic [15:0] base,
                                         input int          nbanks);
        access_t    a;
        logic [15:0] off;
        off    = addr - base;
        a.hit  = (addr >= base) && (32'(off) < nbanks * BANK_STRIDE);
        a.bank = off[7:4];
        a.kind = reg_kind_e'(off[3:2]);
        return a;
    endfunction

endpackage

// File: rtl/ckg_decode.sv
module ckg_decode
    import ckg_pkg::*;
#(
    parameter int             ADDR_W    = 8,
    parameter logic [15:0]    BASE_ADDR = 16'h0024,
    parameter int             NUM_BANKS = 2
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_BANKS-1:0] set_we,
    output logic [NUM_BANKS-1:0] clr_we,
    output logic              rd_en,
    output access_t           acc
);

    assign acc   = map_addr(16'(addr), BASE_ADDR, NUM_BANKS);
    assign rd_en = valid && !write;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        logic sel;
        assign sel       = valid && write && acc.hit && (acc.bank == 4'(b));
        assign set_we[b] = sel && (acc.kind == KIND_SET);
        assign clr_we[b] = sel && (acc.kind == KIND_CLR);
    end

endmodule

// File: rtl/ckg_bank.sv
module ckg_bank #(
    parameter int           W       = 32,
    parameter int           DELAY   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] req,
    output logic [W-1:0] status
);

    localparam int CW = $clog2(DELAY + 1);

    logic [W-1:0] set_m, clr_m;
    logic [W-1:0] pipe [DELAY];

    assign set_m = set_we ? wdata : '0;
    assign clr_m = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) req <= RST_VAL;
        else     req <= (req | set_m) & ~clr_m;
    end

    for (genvar k = 0; k < DELAY; k++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)         pipe[k] <= RST_VAL;
            else if (k == 0) pipe[k] <= req;
            else             pipe[k] <= pipe[(k == 0) ? 0 : k-1];
        end
    end

    assign status = pipe[DELAY-1];

    // Settle tracker for the delay check: cycles since req last changed.
    logic [W-1:0]  req_prev;
    logic [CW-1:0] settle;
    always_ff @(posedge clk) begin
        if (rst) begin
            req_prev <= RST_VAL;
            settle   <= CW'(DELAY);
        end else begin
            req_prev <= req;
            if (req != req_prev)            settle <= '0;
            else if (settle != CW'(DELAY))  settle <= settle + 1'b1;
        end
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we) |=> ((req & $past(wdata)) == $past(wdata)));

    assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((req & $past(wdata)) == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(req));

    assert_delay_R6: assert property (@(posedge clk) disable iff (rst)
        ((req == req_prev) && (settle >= CW'(DELAY - 1))) |-> (status == req));

endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
    import ckg_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          NUM_BANKS    = 2,
    parameter int          STATUS_DELAY = 2,
    parameter logic [15:0] BASE_ADDR    = 16'h0024,
    parameter logic [NUM_BANKS*DATA_W-1:0] RESET_EN = (NUM_BANKS*DATA_W)'(4)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_BANKS*DATA_W-1:0] gate_en
);

    logic [NUM_BANKS-1:0] set_we, clr_we;
    logic                 rd_en;
    access_t              acc;
    logic [DATA_W-1:0]    req_w  [NUM_BANKS];
    logic [DATA_W-1:0]    stat_w [NUM_BANKS];
    logic [DATA_W-1:0]    rd_mux;

    ckg_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .NUM_BANKS(NUM_BANKS)
    ) u_decode (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .set_we(set_we),
        .clr_we(clr_we),
        .rd_en (rd_en),
        .acc   (acc)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ckg_bank #(
            .W      (DATA_W),
            .DELAY  (STATUS_DELAY),
            .RST_VAL(RESET_EN[b*DATA_W +: DATA_W])
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .set_we(set_we[b]),
            .clr_we(clr_we[b]),
            .wdata (bus_wdata),
            .req   (req_w[b]),
            .status(stat_w[b])
        );
        assign gate_en[b*DATA_W +: DATA_W] = stat_w[b];
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (acc.hit && acc.bank == 4'(b)) begin
                case (acc.kind)
                    KIND_REQ:  rd_mux = req_w[b];
                    KIND_STAT: rd_mux = stat_w[b];
                    default:   rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    assert_wo_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && acc.hit && (acc.kind == KIND_SET || acc.kind == KIND_CLR))
        |=> (bus_rdata == '0));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !acc.hit) |=> (bus_rdata == '0));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/ckg_ctrl_bench.sv
module ckg_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] gate_en;

    int checks = 0;
    int fails  = 0;

    logic [63:0] mreq;            // bench model of requests
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        fire = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckg_ctrl u_ckg_ctrl (
        .clk      (clk),
        .rst      (rst),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .gate_en  (gate_en)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge, holds the access for one rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            8'h24: mreq[31:0]  = mreq[31:0]  | d;
            8'h28: mreq[31:0]  = mreq[31:0]  & ~d;
            8'h34: mreq[63:32] = mreq[63:32] | d;
            8'h38: mreq[63:32] = mreq[63:32] & ~d;
            default: ;
        endcase
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each read result on the falling edge after its sampling edge.
    always @(posedge clk) fire <= bus_valid && !bus_write;
    always @(negedge clk) begin
        if (fire) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        mreq = 64'h4;
        repeat (3) @(negedge clk);
        check("R1 gate_en in reset", gate_en, 64'h4);
        rst = 1'b0;
        check("R1 gate_en after reset", gate_en, 64'h4);
        rd(8'h2C, 32'h4, "R1 bank0 request");
        rd(8'h30, 32'h4, "R1 bank0 status");
        rd(8'h3C, 32'h0, "R1 bank1 request");
        rd(8'h40, 32'h0, "R1 bank1 status");

        // R2/R5/R6: set, then exact status latency via back-to-back reads
        wr(8'h24, 32'h0000_00F0);
        rd(8'h30, 32'h4,  "R6 status old at E+1");
        rd(8'h30, 32'h4,  "R6 status old at E+2");
        rd(8'h30, 32'hF4, "R6 status new at E+3");
        rd(8'h2C, mreq[31:0], "R5 request after set");
        check("R2 model set", mreq[31:0], 64'hF4);

        // R3: clear subset
        wr(8'h28, 32'h0000_0030);
        rd(8'h2C, 32'hC4, "R3 request after clear");
        // R2: set of bits already set changes nothing
        wr(8'h24, 32'h0000_0004);
        rd(8'h2C, 32'hC4, "R2 re-set leaves request");

        // R4: clocks 32 and 63 live in bank 1
        wr(8'h34, 32'h8000_0001);
        idle(3);
        check("R4 gate_en ids 32 63", gate_en, {32'h8000_0001, 32'h0000_00C4});
        rd(8'h40, 32'h8000_0001, "R4 bank1 status");
        rd(8'h30, 32'h0000_00C4, "R4 bank0 untouched");

        // R6: gate_en latency for a clear of clock 32
        wr(8'h38, 32'h0000_0001);
        check("R6 gate_en[32] after E",   64'(gate_en[32]), 64'd1);
        idle(1);
        check("R6 gate_en[32] after E+1", 64'(gate_en[32]), 64'd1);
        idle(1);
        check("R6 gate_en[32] after E+2", 64'(gate_en[32]), 64'd0);

        // R7: writes to readback words ignored, set/clear read as zero
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0000_0000);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h2C, 32'hC4, "R7 bank0 request unchanged");
        rd(8'h3C, 32'h8000_0000, "R7 bank1 request unchanged");
        rd(8'h24, 32'h0, "R7 set port reads zero");
        rd(8'h38, 32'h0, "R7 clear port reads zero");
        idle(3);
        check("R7 gate_en unchanged", gate_en, {32'h8000_0000, 32'h0000_00C4});

        // R8: unmapped and unaligned addresses
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R8 unmapped low reads zero");
        rd(8'h44, 32'h0, "R8 unmapped high reads zero");
        rd(8'h2E, 32'hC4, "R8 low address bits ignored");
        idle(2);
        check("R8 rdata holds without read", 64'(bus_rdata), 64'hC4);
        idle(3);
        check("R8 unmapped writes ignored", gate_en, {32'h8000_0000, 32'h0000_00C4});

        // R1: reset in mid-run
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        mreq = 64'h4;
        check("R1 gate_en after mid-run reset", gate_en, 64'h4);
        rd(8'h3C, 32'h0, "R1 bank1 request after reset");
        rd(8'h2C, 32'h4, "R1 bank0 request after reset");

        idle(3);
        check("R8 all reads answered", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule